// File: doc/BRIEF.md
# Seedable Transmit Stream Scrambler

This block is the transmit-side stream cipher of a 100 Mb/s twisted-pair port. On every 25 MHz symbol clock it takes one 5-bit code group from the block encoder. It XORs each bit of that group with a key bit from an 11-bit linear feedback shift register, then registers the scrambled symbol for the serializer. Scrambling spreads the energy launched onto the cable over a wide band.

The key register can be reseeded at run time. The seed joins the port's PHY address with a user-chosen field, so each port of a multi-port system can run a different key sequence. This lowers the combined emissions of a repeater. A test bypass sends the code groups through unscrambled while the key register keeps running.

Top module: `scr_top`

## Requirements
- R1: While `rst` is high and in the cycle after it, `out_vld` and `out_sym` are 0. The key register restarts from the default state 11'h7FF.
- R2: Bit i of `out_sym` is `in_sym[i]` XOR key bit i. Key bits come from the recursion x[n] = x[n-11] XOR x[n-9]. Bit 0 takes the first new key bit and bit 4 takes the fifth.
- R3: The output is registered. `out_vld` equals `in_vld` from the previous cycle, and `out_sym` carries that cycle's symbol.
- R4: Each cycle with `in_vld` high advances the key register by exactly five steps. A cycle with `in_vld` low and no load leaves it unchanged.
- R5: A cycle with `seed_ld` high loads the seed {`port_addr`, `user_seed`} into the key register. `port_addr` forms seed bits 10:6 and `user_seed` forms bits 5:0. The next valid symbol is scrambled with key bits generated from that seed.
- R6: A load of an all-zero seed puts 11'h7FF into the key register instead, so the key register is never zero.
- R7: If `seed_ld` and `in_vld` are high in the same cycle, the symbol is scrambled with the key from before the load. The register then holds the seed, not an advanced state.
- R8: With `bypass` high, `out_sym` equals `in_sym`. The key register still advances for that symbol.
- R9: When `out_vld` is 0, `out_sym` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz symbol clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | Code group on `in_sym` is valid |
| in_sym | input | 5 | Code group from the encoder, bit 0 sent first |
| bypass | input | 1 | Pass code groups through unscrambled |
| seed_ld | input | 1 | Load the seed into the key register |
| port_addr | input | 5 | PHY address, seed bits 10:6 |
| user_seed | input | 6 | User seed field, seed bits 5:0 |
| out_vld | output | 1 | Scrambled symbol on `out_sym` is valid |
| out_sym | output | 5 | Scrambled symbol to the serializer |

## Verification
A seed load and a valid symbol can arrive in the same cycle. In that cycle the load must override the five-step advance, while the symbol still uses the key from before the load. The bench raises `seed_ld` and `in_vld` together, with a symbol of zeros that exposes the key directly. It expects the old key on that symbol. On the following symbol it expects key bits from the fresh seed, not from an advanced state. Bypass overlapping with normal advance is judged the same way: the next scrambled symbol must show a key that moved on by five steps.

// File: rtl/scr_pkg.sv
package scr_pkg;

    localparam int SYM_W    = 5;
    localparam int LFSR_W   = 11;
    localparam int TAP_FAR  = 11;
    localparam int TAP_NEAR = 9;
    localparam int ADDR_W   = 5;
    localparam int USER_W   = 6;
    localparam logic [LFSR_W-1:0] SEED_DFLT = 11'h7FF;

    typedef logic [LFSR_W-1:0] lfsr_t;
    typedef logic [SYM_W-1:0]  sym_t;

    typedef struct packed {
        lfsr_t st;
        sym_t  key;
    } adv_t;

    typedef enum logic [1:0] {
        K_HOLD = 2'd0,
        K_STEP = 2'd1,
        K_LOAD = 2'd2
    } kop_t;

    // st[0] is the newest history bit, st[LFSR_W-1] the oldest
    function automatic adv_t lfsr_run(input lfsr_t s);
        adv_t r;
        logic nb;
        r.st  = s;
        r.key = '0;
        for (int i = 0; i < SYM_W; i++) begin
            nb       = r.st[TAP_FAR-1] ^ r.st[TAP_NEAR-1];
            r.key[i] = nb;
            r.st     = {r.st[LFSR_W-2:0], nb};
        end
        return r;
    endfunction

endpackage

// File: rtl/scr_seed_mux.sv
module scr_seed_mux
    import scr_pkg::*;
(
    input  logic [ADDR_W-1:0] port_addr,
    input  logic [USER_W-1:0] user_seed,
    output lfsr_t             seed
);
    localparam int RAW_W = ADDR_W + USER_W;

    logic [RAW_W-1:0] raw;

    assign raw  = {port_addr, user_seed};
    assign seed = (raw == '0) ? SEED_DFLT : lfsr_t'(raw);
endmodule

// File: rtl/scr_keygen.sv
module scr_keygen
    import scr_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  adv,
    input  logic  load,
    input  lfsr_t seed,
    output sym_t  key,
    output lfsr_t st_q
);
    kop_t op;
    adv_t nxt;

    assign nxt = lfsr_run(st_q);
    assign key = nxt.key;

    always_comb begin
        if (load)     op = K_LOAD;
        else if (adv) op = K_STEP;
        else          op = K_HOLD;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= SEED_DFLT;
        end else begin
            case (op)
                K_LOAD:  st_q <= seed;
                K_STEP:  st_q <= nxt.st;
                default: st_q <= st_q;
            endcase
        end
    end
endmodule

// File: rtl/scr_mix.sv
module scr_mix
    import scr_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic vld,
    input  sym_t sym,
    input  sym_t key,
    input  logic bypass,
    output logic out_vld,
    output sym_t out_sym
);
    sym_t mixed;

    for (genvar i = 0; i < SYM_W; i++) begin : g_bit
        assign mixed[i] = bypass ? sym[i] : (sym[i] ^ key[i]);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld <= 1'b0;
            out_sym <= '0;
        end else begin
            out_vld <= vld;
            out_sym <= vld ? mixed : '0;
        end
    end
endmodule

// File: rtl/scr_top.sv
module scr_top
    import scr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              in_vld,
    input  logic [SYM_W-1:0]  in_sym,
    input  logic              bypass,
    input  logic              seed_ld,
    input  logic [ADDR_W-1:0] port_addr,
    input  logic [USER_W-1:0] user_seed,
    output logic              out_vld,
    output logic [SYM_W-1:0]  out_sym
);
    lfsr_t seed;
    lfsr_t st_q;
    sym_t  key;

    scr_seed_mux u_seed (
        .port_addr (port_addr),
        .user_seed (user_seed),
        .seed      (seed)
    );

    scr_keygen u_key (
        .clk  (clk),
        .rst  (rst),
        .adv  (in_vld),
        .load (seed_ld),
        .seed (seed),
        .key  (key),
        .st_q (st_q)
    );

    scr_mix u_mix (
        .clk     (clk),
        .rst     (rst),
        .vld     (in_vld),
        .sym     (in_sym),
        .key     (key),
        .bypass  (bypass),
        .out_vld (out_vld),
        .out_sym (out_sym)
    );
endmodule

// File: rtl/scr_chk.sv
module scr_chk
    import scr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              in_vld,
    input logic [SYM_W-1:0]  in_sym,
    input logic              bypass,
    input logic              seed_ld,
    input logic [ADDR_W-1:0] port_addr,
    input logic [USER_W-1:0] user_seed,
    input logic              out_vld,
    input logic [SYM_W-1:0]  out_sym,
    input lfsr_t             st
);
    // R3
    vld_follow_chk: assert property (@(posedge clk) disable iff (rst)
        in_vld |=> out_vld);

    // R3
    idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> !out_vld);

    // R9
    idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !out_vld |-> (out_sym == '0));

    // R8
    bypass_pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_vld && bypass) |=> (out_sym == $past(in_sym)));

    // R4
    hold_state_chk: assert property (@(posedge clk) disable iff (rst)
        (!in_vld && !seed_ld) |=> $stable(st));

    // R5
    seed_take_chk: assert property (@(posedge clk) disable iff (rst)
        (seed_ld && ({port_addr, user_seed} != '0)) |=> (st == $past({port_addr, user_seed})));

    // R6
    zero_seed_chk: assert property (@(posedge clk) disable iff (rst)
        (seed_ld && ({port_addr, user_seed} == '0)) |=> (st == SEED_DFLT));

    // R6
    never_zero_chk: assert property (@(posedge clk) disable iff (rst)
        st != '0);
endmodule

bind scr_top scr_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_vld    (in_vld),
    .in_sym    (in_sym),
    .bypass    (bypass),
    .seed_ld   (seed_ld),
    .port_addr (port_addr),
    .user_seed (user_seed),
    .out_vld   (out_vld),
    .out_sym   (out_sym),
    .st        (st_q)
);

// File: tb/test_scr_top.sv
module test_scr_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       in_vld = 1'b0;
    logic [4:0] in_sym = '0;
    logic       bypass = 1'b0;
    logic       seed_ld = 1'b0;
    logic [4:0] port_addr = '0;
    logic [5:0] user_seed = '0;
    logic       out_vld;
    logic [4:0] out_sym;

    int checks = 0;
    int errors = 0;
    logic [10:0] model = 11'h7FF;

    always #10 clk = ~clk;

    scr_top i_scr_top (
        .clk       (clk),
        .rst       (rst),
        .in_vld    (in_vld),
        .in_sym    (in_sym),
        .bypass    (bypass),
        .seed_ld   (seed_ld),
        .port_addr (port_addr),
        .user_seed (user_seed),
        .out_vld   (out_vld),
        .out_sym   (out_sym)
    );

    // history h[0] oldest .. h[10] newest; h[11+j] = h[j] ^ h[j+2]
    function automatic logic [15:0] ref_gen(input logic [10:0] s);
        logic [15:0] h;
        logic [10:0] ns;
        logic [4:0]  k;
        h = '0;
        for (int i = 0; i < 11; i++) h[i] = s[10-i];
        for (int j = 0; j < 5; j++) begin
            h[11+j] = h[j] ^ h[j+2];
            k[j]    = h[11+j];
        end
        for (int i = 0; i < 11; i++) ns[i] = h[15-i];
        return {ns, k};
    endfunction

    task automatic check(input string req, input logic [5:0] got, input logic [5:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, got, exp);
        end
    endtask

    // one cycle: drive at negedge, check registered result at the next negedge
    task automatic send(input string req, input logic [4:0] sym, input logic byp,
                        input logic ld, input logic [4:0] pa, input logic [5:0] us);
        logic [15:0] g;
        logic [4:0]  exp;
        g   = ref_gen(model);
        exp = byp ? sym : (sym ^ g[4:0]);
        in_vld = 1'b1; in_sym = sym; bypass = byp;
        seed_ld = ld; port_addr = pa; user_seed = us;
        @(negedge clk);
        check(req, {out_vld, out_sym}, {1'b1, exp});
        if (ld) model = ({pa, us} == '0) ? 11'h7FF : {pa, us};
        else    model = g[15:5];
        in_vld = 1'b0; seed_ld = 1'b0; bypass = 1'b0; in_sym = '0;
    endtask

    task automatic idle(input string req, input logic ld, input logic [4:0] pa, input logic [5:0] us);
        in_vld = 1'b0; seed_ld = ld; port_addr = pa; user_seed = us;
        in_sym = 5'h1F;
        @(negedge clk);
        check(req, {out_vld, out_sym}, 6'd0);
        if (ld) model = ({pa, us} == '0) ? 11'h7FF : {pa, us};
        seed_ld = 1'b0; in_sym = '0;
    endtask

    task automatic t_reset();
        rst = 1'b1;
        in_vld = 1'b1; in_sym = 5'h15;
        repeat (3) @(negedge clk);
        check("R1 during reset", {out_vld, out_sym}, 6'd0);
        rst = 1'b0; in_vld = 1'b0; in_sym = '0;
        @(negedge clk);
        check("R1 after reset", {out_vld, out_sym}, 6'd0);
        model = 11'h7FF;
        send("R1 first key from default", 5'h00, 1'b0, 1'b0, 5'h0, 6'h0);
    endtask

    task automatic t_stream();
        send("R2 zeros", 5'h00, 1'b0, 1'b0, 5'h0, 6'h0);
        send("R2 ones", 5'h1F, 1'b0, 1'b0, 5'h0, 6'h0);
        send("R2 alt", 5'h0A, 1'b0, 1'b0, 5'h0, 6'h0);
        for (int i = 0; i < 40; i++)
            send("R3 back-to-back", 5'((i * 7) + 3), 1'b0, 1'b0, 5'h0, 6'h0);
    endtask

    task automatic t_hold();
        idle("R9 gap", 1'b0, 5'h0, 6'h0);
        idle("R4 gap", 1'b0, 5'h0, 6'h0);
        idle("R4 gap", 1'b0, 5'h0, 6'h0);
        send("R4 resume unchanged", 5'h00, 1'b0, 1'b0, 5'h0, 6'h0);
    endtask

    task automatic t_seed();
        idle("R5 load idle", 1'b1, 5'h13, 6'h2D);
        send("R5 key from seed", 5'h00, 1'b0, 1'b0, 5'h0, 6'h0);
        send("R5 second after seed", 5'h07, 1'b0, 1'b0, 5'h0, 6'h0);
        idle("R5 load addr only", 1'b1, 5'h01, 6'h00);
        send("R5 addr-only seed", 5'h00, 1'b0, 1'b0, 5'h0, 6'h0);
    endtask

    task automatic t_zero();
        idle("R6 zero load", 1'b1, 5'h0, 6'h0);
        send("R6 zero seed substituted", 5'h00, 1'b0, 1'b0, 5'h0, 6'h0);
        for (int i = 0; i < 10; i++)
            send("R6 running", 5'h00, 1'b0, 1'b0, 5'h0, 6'h0);
    endtask

    task automatic t_collide();
        send("R7 load+valid old key", 5'h00, 1'b0, 1'b1, 5'h0C, 6'h31);
        send("R7 next uses seed", 5'h00, 1'b0, 1'b0, 5'h0, 6'h0);
        send("R7 load+valid old key 2", 5'h1B, 1'b0, 1'b1, 5'h1F, 6'h3F);
        send("R7 next uses seed 2", 5'h1B, 1'b0, 1'b0, 5'h0, 6'h0);
    endtask

    task automatic t_bypass();
        send("R8 bypass", 5'h16, 1'b1, 1'b0, 5'h0, 6'h0);
        send("R8 bypass", 5'h09, 1'b1, 1'b0, 5'h0, 6'h0);
        send("R8 key advanced under bypass", 5'h00, 1'b0, 1'b0, 5'h0, 6'h0);
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                t_reset();
                t_stream();
                t_hold();
                t_seed();
                t_zero();
                t_collide();
                t_bypass();
                t_stream();
            end
            begin
                repeat (20000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog expired");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule